// File: doc/BRIEF.md
# Word-Aligned Multi-Cycle Processor Core

This block is a small 32-bit processor core. It has sixteen 32-bit general registers, a program counter, a downward-growing stack pointer and three status flags. It runs a sequential fetch, decode and execute loop. Every instruction is made of whole aligned 32-bit words: an opcode word followed by zero, one or two operand words. An instruction is therefore 4, 8 or 12 bytes long. The core reaches a byte-addressed memory through a single request port with a 16-bit address. Each read or write is offered with a valid/ready handshake, and each read is completed by a separate response strobe.

The core supports immediate load, register copy, add, subtract, unconditional and zero-conditional jumps, subroutine call and return, and halt. An opcode word that matches no known encoding stops the core, just as a halt does. Each register-file update is reported on a write-back strobe, together with the register index and the value. The packed flag byte is visible at all times. Software results can therefore be observed without a debug path.

Top module: `wcpu_core`

## Requirements
- R1: After reset the first request is a read of byte address 0. The flags output is 0 and halted is low. Every general register reads as 0, and the stack pointer is 0x10000.
- R2: The full 32-bit opcode word is decoded with these values: load 0x10, move 0x11, add 0x30, subtract 0x31, halt 0x01, jump 0x40, jump-if-zero 0x41, jump-if-not-zero 0x42, call 0x72, return 0x73. The four register/data instructions read operands at PC+4 and PC+8 and advance the PC by 12. The jumps and call read one address word at PC+4, and a jump that is not taken advances the PC by 8. Halt and return are one word long.
- R3: A register operand word selects the register given by its low 4 bits only. The other bits are ignored.
- R4: Load writes the second operand word into the register named by the first operand. Move copies the register named by the second operand into the register named by the first. Each register write appears on wb_valid/wb_idx/wb_data in the cycle after the instruction executes.
- R5: Add stores the 32-bit sum in the first register. It sets Z (flags bit 0) when the sum is zero, C (bit 1) when the sum is below the first operand as an unsigned value, and N (bit 2) from sum bit 31.
- R6: Subtract stores first minus second. It sets Z and N in the same way as add, and it sets C when the first operand is below the second as an unsigned value.
- R7: Only add and subtract change the flags. The new flags are visible in the same cycle as their write-back strobe.
- R8: Jump loads the PC with the low 16 bits of its address word. Jump-if-zero does so only when Z is 1, and jump-if-not-zero only when Z is 0. A taken jump does not also advance the PC.
- R9: Call first lowers SP by 4. It then writes the return address PC+8 to the new SP, and then jumps to its target, so the first call writes to 0xFFFC. Return reads the PC from SP and then raises SP by 4.
- R10: An opcode word that matches none of the encodings in R2 halts the core. No later instruction takes effect.
- R11: Once raised, halted stays high until reset, and the core issues no further memory request.
- R12: A request is held with an unchanged address, direction and write data until ready is seen. The core waits for the read response before it goes on. All addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 16 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_rdata | input | 32 | Read data |
| halted | output | 1 | Core has stopped |
| flags | output | 3 | Z in bit 0, C in bit 1, N in bit 2 |
| wb_valid | output | 1 | A general register was written |
| wb_idx | output | 4 | Index of the written register |
| wb_data | output | 32 | Value written |

## Verification
A register write, and any flag change that goes with it, appears one cycle after the execute edge. That edge follows the last operand response. A stack write is visible in the cycle in which the core offers it and the memory accepts it.

The bench model throttles ready on a repeating pattern, which shifts all of these instants. For that reason the bench does not predict absolute cycles. It queues the expected write-backs and stack writes in program order, and a monitor compares each event at the falling edge of the cycle in which it occurs. A halt is followed by an idle window in which any request counts as an error.

// File: rtl/wcpu_pkg.sv
// Package: shared encodings and state type for the word-aligned core.
// Assumes opcodes are full 32-bit words compared exactly.
package wcpu_pkg;
    localparam logic [31:0] OP_HLT  = 32'h01;
    localparam logic [31:0] OP_LOAD = 32'h10;
    localparam logic [31:0] OP_MOV  = 32'h11;
    localparam logic [31:0] OP_ADD  = 32'h30;
    localparam logic [31:0] OP_SUB  = 32'h31;
    localparam logic [31:0] OP_JMP  = 32'h40;
    localparam logic [31:0] OP_JZ   = 32'h41;
    localparam logic [31:0] OP_JNZ  = 32'h42;
    localparam logic [31:0] OP_CALL = 32'h72;
    localparam logic [31:0] OP_RET  = 32'h73;

    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;
    localparam int FLAG_N = 2;

    typedef enum logic [3:0] {
        ST_FETCH, ST_FWAIT, ST_A1, ST_A1W, ST_A2, ST_A2W,
        ST_EXEC, ST_PUSH, ST_POP, ST_POPW, ST_HALT
    } cpu_state_e;

    // Number of operand words that follow an opcode word.
    function automatic logic [1:0] arg_count(input logic [31:0] op);
        case (op)
            OP_LOAD, OP_MOV, OP_ADD, OP_SUB: return 2'd2;
            OP_JMP, OP_JZ, OP_JNZ, OP_CALL:  return 2'd1;
            default:                         return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/wcpu_regfile.sv
// Register file: NREG words, two asynchronous read ports, one write port.
// Assumes every entry clears on synchronous active-low reset.
module wcpu_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] regs [NREG];

    // Storage update: clear on reset, otherwise single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    // Read ports.
    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
endmodule

// File: rtl/wcpu_alu.sv
// Adder/subtractor with zero, carry/borrow and sign flag outputs.
// Assumes unsigned carry semantics: add carries on wrap, subtract on borrow.
module wcpu_alu #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] res,
    output logic              fz,
    output logic              fc,
    output logic              fn
);
    // Result and flag generation.
    always_comb begin
        if (do_sub) begin
            res = a - b;
            fc  = (a < b);
        end else begin
            res = a + b;
            fc  = (res < a);
        end
        fz = (res == '0);
        fn = res[DATA_W-1];
    end
endmodule

// File: rtl/wcpu_core.sv
// Multi-cycle core: fetches word-aligned instructions one word per request,
// executes register, flag, branch and stack operations, halts on HLT or
// an unknown opcode. Assumes one outstanding read at a time, answered by
// mem_rsp_valid in a later cycle than its acceptance.
module wcpu_core
    import wcpu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              halted,
    output logic [2:0]        flags,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data
);
    localparam logic [ADDR_W:0]   SP_INIT = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W-1:0] STEP1   = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP2   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] STEP3   = ADDR_W'(12);

    cpu_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W:0]   sp_q;
    logic [DATA_W-1:0] opc_q;
    logic [ADDR_W-1:0] arg1_q;
    logic [DATA_W-1:0] arg2_q;
    logic [2:0]        flags_q;
    logic              wbv_q;
    logic [IDX_W-1:0]  wbi_q;
    logic [DATA_W-1:0] wbd_q;

    logic [IDX_W-1:0]  ra_idx, rb_idx;
    logic [DATA_W-1:0] ra_data, rb_data, alu_res, rf_wdata;
    logic              alu_z, alu_c, alu_n, rf_we, is_arith;

    assign ra_idx   = arg1_q[IDX_W-1:0];
    assign rb_idx   = arg2_q[IDX_W-1:0];
    assign is_arith = (opc_q == OP_ADD) || (opc_q == OP_SUB);
    assign rf_we    = (state_q == ST_EXEC) &&
                      (is_arith || opc_q == OP_LOAD || opc_q == OP_MOV);

    wcpu_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(ra_idx), .wdata(rf_wdata),
        .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_data(ra_data), .rb_data(rb_data)
    );

    wcpu_alu #(.DATA_W(DATA_W)) u_alu (
        .a(ra_data), .b(rb_data), .do_sub(opc_q == OP_SUB),
        .res(alu_res), .fz(alu_z), .fc(alu_c), .fn(alu_n)
    );

    // Write-back value selection.
    always_comb begin
        case (opc_q)
            OP_LOAD: rf_wdata = arg2_q;
            OP_MOV:  rf_wdata = rb_data;
            default: rf_wdata = alu_res;
        endcase
    end

    // Memory request generation from the current state.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = pc_q;
        mem_req_wdata = DATA_W'(pc_q + STEP2);
        case (state_q)
            ST_FETCH: mem_req_valid = 1'b1;
            ST_A1:    begin mem_req_valid = 1'b1; mem_req_addr = pc_q + STEP1; end
            ST_A2:    begin mem_req_valid = 1'b1; mem_req_addr = pc_q + STEP2; end
            ST_PUSH:  begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = sp_q[ADDR_W-1:0];
            end
            ST_POP:   begin mem_req_valid = 1'b1; mem_req_addr = sp_q[ADDR_W-1:0]; end
            default:  ;
        endcase
    end

    // Sequencer: fetch, operand reads, execute, stack access, halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            sp_q    <= SP_INIT;
            opc_q   <= '0;
            arg1_q  <= '0;
            arg2_q  <= '0;
            flags_q <= '0;
            wbv_q   <= 1'b0;
            wbi_q   <= '0;
            wbd_q   <= '0;
        end else begin
            wbv_q <= rf_we;
            if (rf_we) begin
                wbi_q <= ra_idx;
                wbd_q <= rf_wdata;
            end
            case (state_q)
                ST_FETCH: if (mem_req_ready) state_q <= ST_FWAIT;
                ST_FWAIT: if (mem_rsp_valid) begin
                    opc_q <= mem_rsp_rdata;
                    if (arg_count(mem_rsp_rdata) != 2'd0) begin
                        state_q <= ST_A1;
                    end else if (mem_rsp_rdata == OP_RET) begin
                        state_q <= ST_POP;
                    end else begin
                        pc_q    <= pc_q + STEP1;
                        state_q <= ST_HALT;
                    end
                end
                ST_A1:    if (mem_req_ready) state_q <= ST_A1W;
                ST_A1W:   if (mem_rsp_valid) begin
                    arg1_q  <= mem_rsp_rdata[ADDR_W-1:0];
                    state_q <= (arg_count(opc_q) == 2'd2) ? ST_A2 : ST_EXEC;
                end
                ST_A2:    if (mem_req_ready) state_q <= ST_A2W;
                ST_A2W:   if (mem_rsp_valid) begin
                    arg2_q  <= mem_rsp_rdata;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH;
                    case (opc_q)
                        OP_LOAD, OP_MOV: pc_q <= pc_q + STEP3;
                        OP_ADD, OP_SUB: begin
                            pc_q    <= pc_q + STEP3;
                            flags_q <= {alu_n, alu_c, alu_z};
                        end
                        OP_JMP:  pc_q <= arg1_q;
                        OP_JZ:   pc_q <= flags_q[FLAG_Z]  ? arg1_q : pc_q + STEP2;
                        OP_JNZ:  pc_q <= !flags_q[FLAG_Z] ? arg1_q : pc_q + STEP2;
                        OP_CALL: begin
                            sp_q    <= sp_q - (ADDR_W+1)'(4);
                            state_q <= ST_PUSH;
                        end
                        default: state_q <= ST_HALT;
                    endcase
                end
                ST_PUSH:  if (mem_req_ready) begin
                    pc_q    <= arg1_q;
                    state_q <= ST_FETCH;
                end
                ST_POP:   if (mem_req_ready) state_q <= ST_POPW;
                ST_POPW:  if (mem_rsp_valid) begin
                    pc_q    <= mem_rsp_rdata[ADDR_W-1:0];
                    sp_q    <= sp_q + (ADDR_W+1)'(4);
                    state_q <= ST_FETCH;
                end
                default:  state_q <= ST_HALT;
            endcase
        end
    end

    assign halted   = (state_q == ST_HALT);
    assign flags    = flags_q;
    assign wb_valid = wbv_q;
    assign wb_idx   = wbi_q;
    assign wb_data  = wbd_q;
endmodule

// File: rtl/wcpu_core_chk.sv
// Checker for wcpu_core: port-level temporal properties, bound to the top.
// Assumes synchronous active-low reset.
module wcpu_core_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              halted,
    input logic [2:0]        flags,
    input logic              wb_valid
);
    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req_valid);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid &&
        $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

    // R12
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    // R7
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags) |-> wb_valid);
endmodule

bind wcpu_core wcpu_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wcpu_core_bench.sv
// Scoreboard bench: programs are placed in a word memory model, expected
// write-backs and stack writes are queued, and monitors compare them.
module wcpu_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_ready, req_write;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        halted, wb_valid;
    logic [2:0]  flags;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data;

    int n_chk = 0;
    int n_err = 0;

    typedef struct { logic [3:0] idx; logic [31:0] data; logic [2:0] fl; string req; } wb_item_t;
    typedef struct { logic [15:0] addr; logic [31:0] data; string req; } push_item_t;
    wb_item_t   wb_q[$];
    push_item_t push_q[$];

    logic [31:0] mem [MEM_WORDS];
    int          wp;
    int          rdy_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    wcpu_core u_wcpu_core (
        .clk(clk), .rst_n(rst_n),
        .mem_req_valid(req_valid), .mem_req_ready(req_ready),
        .mem_req_write(req_write), .mem_req_addr(req_addr),
        .mem_req_wdata(req_wdata), .mem_rsp_valid(rsp_valid),
        .mem_rsp_rdata(rsp_rdata), .halted(halted), .flags(flags),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Memory model: throttled ready, read data one cycle after acceptance.
    always @(posedge clk) begin
        rdy_cnt   <= rdy_cnt + 1;
        req_ready <= (rdy_cnt % 3) != 2;
        rsp_valid <= 1'b0;
        if (rst_n && req_valid && req_ready) begin
            if (req_write) mem[req_addr[11:2]] <= req_wdata;
            else begin
                rsp_valid <= 1'b1;
                rsp_rdata <= mem[req_addr[11:2]];
            end
        end
    end

    // Monitor: write-backs and stack writes against the queues.
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (wb_q.size() == 0) check("R4 unexpected write-back", {28'd0, wb_idx}, 32'hFFFF_FFFF);
            else begin
                wb_item_t e;
                e = wb_q.pop_front();
                check({e.req, " wb index"}, {28'd0, wb_idx}, {28'd0, e.idx});
                check({e.req, " wb data"}, wb_data, e.data);
                check({e.req, " flags"}, {29'd0, flags}, {29'd0, e.fl});
            end
        end
        if (rst_n && req_valid && req_ready && req_write) begin
            if (push_q.size() == 0) check("R9 unexpected write", {16'd0, req_addr}, 32'hFFFF_FFFF);
            else begin
                push_item_t p;
                p = push_q.pop_front();
                check({p.req, " push address"}, {16'd0, req_addr}, {16'd0, p.addr});
                check({p.req, " push data"}, req_wdata, p.data);
            end
        end
    end

    task automatic put(input logic [31:0] w);
        mem[wp] = w;
        wp++;
    endtask

    task automatic exp_wb(input logic [3:0] i, input logic [31:0] d, input logic [2:0] f, input string rq);
        wb_item_t e;
        e.idx = i; e.data = d; e.fl = f; e.req = rq;
        wb_q.push_back(e);
    endtask

    task automatic exp_push(input logic [15:0] a, input logic [31:0] d, input string rq);
        push_item_t p;
        p.addr = a; p.data = d; p.req = rq;
        push_q.push_back(p);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
        wp = 0;
    endtask

    // Reset, check the reset state, run to halt, then check quiet idle.
    task automatic run_prog(input string name);
        int cnt;
        int reqs;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 halted low", {31'd0, halted}, 32'd0);
        check("R1 flags zero", {29'd0, flags}, 32'd0);
        check("R1 first fetch valid", {31'd0, req_valid}, 32'd1);
        check("R1 first fetch address", {16'd0, req_addr}, 32'd0);
        cnt = 0;
        while (!halted && cnt < 3000) begin
            @(negedge clk);
            cnt++;
        end
        check({"R11 reached halt ", name}, {31'd0, halted}, 32'd1);
        reqs = 0;
        repeat (20) begin
            @(negedge clk);
            if (req_valid) reqs++;
            if (!halted) reqs++;
        end
        check({"R11 quiet after halt ", name}, reqs, 32'd0);
        check({"R2 write-backs consumed ", name}, wb_q.size(), 32'd0);
        check({"R9 pushes consumed ", name}, push_q.size(), 32'd0);
        wb_q.delete();
        push_q.delete();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rdy_cnt = 0;
        // Program A: load, add, jump over a load, halt (R2 R4 R5 R8).
        clear_mem();
        put(32'h10); put(0); put(3);
        put(32'h10); put(1); put(5);
        put(32'h30); put(0); put(1);
        put(32'h40); put(56);
        put(32'h10); put(0); put(32'hDEAD);
        put(32'h01);
        exp_wb(0, 3, 3'b000, "R4 load r0");
        exp_wb(1, 5, 3'b000, "R4 load r1");
        exp_wb(0, 8, 3'b000, "R5 add plain");
        run_prog("A");

        // Program B: flag cases and operand masking (R3 R5 R6 R7 R8).
        clear_mem();
        put(32'h10); put(2); put(32'hFFFF_FFFF);
        put(32'h10); put(32'h23); put(1);
        put(32'h30); put(2); put(3);
        put(32'h42); put(108);
        put(32'h31); put(2); put(3);
        put(32'h10); put(4); put(32'h8000_0000);
        put(32'h11); put(5); put(4);
        put(32'h31); put(5); put(4);
        put(32'h30); put(4); put(4);
        put(32'h01);
        put(32'h10); put(15); put(32'hBAD);
        exp_wb(2, 32'hFFFF_FFFF, 3'b000, "R4 load all ones");
        exp_wb(3, 1, 3'b000, "R3 masked index");
        exp_wb(2, 0, 3'b011, "R5 add wrap zero carry");
        exp_wb(2, 32'hFFFF_FFFF, 3'b110, "R6 sub borrow negative");
        exp_wb(4, 32'h8000_0000, 3'b110, "R7 load keeps flags");
        exp_wb(5, 32'h8000_0000, 3'b110, "R4 move copies");
        exp_wb(5, 0, 3'b001, "R6 sub equal zero");
        exp_wb(4, 0, 3'b011, "R5 add sign overflow");
        run_prog("B");

        // Program C: countdown loop, conditional jumps, two calls (R8 R9).
        clear_mem();
        put(32'h10); put(1); put(3);
        put(32'h10); put(2); put(1);
        put(32'h31); put(1); put(2);
        put(32'h42); put(24);
        put(32'h41); put(64);
        put(32'h10); put(7); put(32'hBAD);
        put(32'h72); put(96);
        put(32'h72); put(96);
        put(32'h10); put(8); put(32'h88);
        put(32'h01);
        put(32'h10); put(9); put(32'h99);
        put(32'h73);
        exp_wb(1, 3, 3'b000, "R4 load counter");
        exp_wb(2, 1, 3'b000, "R4 load step");
        exp_wb(1, 2, 3'b000, "R6 sub no borrow");
        exp_wb(1, 1, 3'b000, "R8 jnz taken");
        exp_wb(1, 0, 3'b001, "R8 jnz loop exit");
        exp_push(16'hFFFC, 72, "R9 first call");
        exp_wb(9, 32'h99, 3'b001, "R9 callee runs");
        exp_push(16'hFFFC, 80, "R9 return restored sp");
        exp_wb(9, 32'h99, 3'b001, "R9 callee again");
        exp_wb(8, 32'h88, 3'b001, "R9 return lands");
        run_prog("C");

        // Program D: reset-zero registers, unknown opcode halts (R1 R10).
        clear_mem();
        put(32'h11); put(6); put(10);
        put(32'h10); put(0); put(7);
        put(32'h110);
        put(32'h10); put(1); put(9);
        exp_wb(6, 0, 3'b000, "R1 register reset zero");
        exp_wb(0, 7, 3'b000, "R10 before unknown");
        run_prog("D");

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule